// File: doc/BRIEF.md
# Down-Counting Interrupt Timer

A 32-bit count register that steps down by one on every cycle in which a tick strobe is high and requests an interrupt as the count runs out. Software loads the register through a write strobe with data and sees the live count on a read port with no side effects. A second copy of the block can act as a separate timer for a privileged software layer; every copy is independent.

A static mode pin picks the request semantics. With mode 0 (edge) the request is a sticky flag: it is set by an underflow event or by certain writes, and it stays set until an acknowledge pulse retires it. With mode 1 (level) the request tracks whether the written value is "negative" (bit 31 set); acknowledge does nothing, and only writes can drop the request. In both modes, loading a tiny value (0, 1 or 2) raises the request straight away, since the event is due before any handler could run.

Top module: `dec_timer`

## Requirements
- R1: While rst_ni is low, and at the first clock after release, the count reads 0xFFFFFFFF and irq_o is 0 in both modes; the reset load itself raises no request.
- R2: A cycle with wr_en_i high loads wr_data_i into the count at that clock edge. This happens even if tick_i is high in the same cycle, and then no decrement takes place. rd_data_o always shows the count register.
- R3: A cycle with tick_i high and wr_en_i low lowers the count by exactly one. The count wraps from 0 to 0xFFFFFFFF. With neither strobe, the count holds.
- R4: In either mode, a tick (with no write) while the count is 2, 1 or 0 sets irq_o at that edge.
- R5: In either mode, a write of 0, 1 or 2 sets irq_o at that edge.
- R6: In edge mode (mode_i=0), a write whose value has bit 31 set sets irq_o when the current count has bit 31 clear. If bit 31 of the count is already set, such a write raises nothing.
- R7: In edge mode, ack_i clears irq_o at the next edge. If a setting event (R4, R5, R6) occurs in the same cycle, the set wins and irq_o stays 1.
- R8: In edge mode, a write that does not set the request leaves irq_o unchanged, unless ack_i clears it.
- R9: In level mode (mode_i=1), a write with bit 31 set sets irq_o.
- R10: In level mode, a write with bit 31 clear and a value of 3 or more clears irq_o.
- R11: In level mode, ack_i has no effect on irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-down enable strobe |
| wr_en_i | input | 1 | Count write strobe |
| wr_data_i | input | 32 | Value to load |
| rd_data_o | output | 32 | Current count |
| ack_i | input | 1 | Interrupt taken; clears an edge-mode request |
| mode_i | input | 1 | 0 = sticky edge request, 1 = sign-bit level request |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle: a write together with a tick, and an acknowledge together with a setting event. The bench provokes the first by writing while the tick is high. It judges the result by reading the count one edge later and expecting the written value, not that value minus one. It provokes the second in edge mode with an acknowledge on the same cycle as a 0-to-all-ones tick and as a write of zero, and expects the request to remain set.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/dec_count.sv
module dec_count #(
  parameter int WIDTH      = 32,
  parameter int FIRE_BELOW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             tick_evt_o
);
  localparam logic [WIDTH-1:0] LIM = WIDTH'(FIRE_BELOW);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (tick_i)  cnt_q <= cnt_q - ONE;
  end

  // underflow event: steps 2->1, 1->0, 0->-1
  assign tick_evt_o = tick_i && !wr_en_i && (cnt_q < LIM);
  assign cnt_o      = cnt_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i));
  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i) |=> cnt_q == $past(cnt_q) - ONE);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dec_irq.sv
module dec_irq
  import dec_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int FIRE_BELOW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  irq_mode_e        mode_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             old_msb_i,
  input  logic             tick_evt_i,
  input  logic             ack_i,
  output logic             irq_o
);
  localparam logic [WIDTH-1:0] LIM = WIDTH'(FIRE_BELOW);

  logic pend_q, pend_d;
  logic wr_small, new_msb, edge_set;

  assign wr_small = wr_en_i && (wr_data_i < LIM);
  assign new_msb  = wr_data_i[WIDTH-1];
  assign edge_set = tick_evt_i || wr_small || (wr_en_i && new_msb && !old_msb_i);

  always_comb begin
    pend_d = pend_q;
    if (mode_i == MODE_EDGE) begin
      if (edge_set)   pend_d = 1'b1;
      else if (ack_i) pend_d = 1'b0;
    end else begin
      if (wr_en_i)         pend_d = wr_small || new_msb;
      else if (tick_evt_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign irq_o = pend_q;

  assert_tick_evt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_evt_i |=> irq_o);
  assert_wr_small_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_small |=> irq_o);
  assert_edge_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && wr_en_i && new_msb && !old_msb_i) |=> irq_o);
  assert_edge_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && ack_i && !wr_en_i && !tick_evt_i) |=> !irq_o);
  assert_edge_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && wr_en_i && !wr_small && !(new_msb && !old_msb_i) && !ack_i)
    |=> $stable(irq_o));
  assert_lvl_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL && wr_en_i && new_msb) |=> irq_o);
  assert_lvl_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL && wr_en_i && !new_msb && !wr_small) |=> !irq_o);
  assert_lvl_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL && !wr_en_i && !tick_evt_i) |=> $stable(irq_o));
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int FIRE_BELOW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             ack_i,
  input  logic             mode_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] cnt;
  logic             tick_evt;
  irq_mode_e        mode;

  assign mode = irq_mode_e'(mode_i);

  dec_count #(.WIDTH(WIDTH), .FIRE_BELOW(FIRE_BELOW)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cnt_o      (cnt),
    .tick_evt_o (tick_evt)
  );

  dec_irq #(.WIDTH(WIDTH), .FIRE_BELOW(FIRE_BELOW)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .old_msb_i  (cnt[WIDTH-1]),
    .tick_evt_i (tick_evt),
    .ack_i      (ack_i),
    .irq_o      (irq_o)
  );

  assign rd_data_o = cnt;

  assert_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (rd_data_o == '1 && !irq_o));
endmodule

// File: tb/dec_timer_tb.sv
module dec_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  typedef struct packed {
    logic        wr;
    logic [31:0] d;
    logic        tick;
    logic        ack;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  // edge-mode sequence from reset
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 32'h5,        1'b1, 1'b0, 32'h5,        1'b0}, // R2 write beats tick
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h4,        1'b0}, // R3
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h3,        1'b0}, // R3
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h2,        1'b0}, // R4 3->2 quiet
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h1,        1'b1}, // R4 2->1 fires
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h1,        1'b0}, // R7 ack clears
    '{1'b0, 32'h0,        1'b0, 1'b0, 32'h1,        1'b0}, // R3 hold
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h0,        1'b1}, // R4 1->0
    '{1'b0, 32'h0,        1'b1, 1'b1, 32'hFFFFFFFF, 1'b1}, // R7 set beats ack
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'hFFFFFFFF, 1'b0}, // R7
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'hFFFFFFFE, 1'b0}, // R3 wrap, no refire
    '{1'b1, 32'h80000010, 1'b0, 1'b0, 32'h80000010, 1'b0}, // R6 msb already set
    '{1'b1, 32'h100,      1'b0, 1'b0, 32'h100,      1'b0}, // R8
    '{1'b1, 32'h80000000, 1'b0, 1'b0, 32'h80000000, 1'b1}, // R6 msb 0->1
    '{1'b1, 32'h40,       1'b0, 1'b0, 32'h40,       1'b1}, // R8 kept
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h40,       1'b0}, // R7
    '{1'b1, 32'h2,        1'b0, 1'b0, 32'h2,        1'b1}, // R5
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h2,        1'b0}, // R7
    '{1'b1, 32'h0,        1'b0, 1'b1, 32'h0,        1'b1}, // R5 beats ack
    '{1'b1, 32'h7,        1'b0, 1'b1, 32'h7,        1'b0}  // R8 ack still clears
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0, ack = 1'b0, mode = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_data_i(wdata), .rd_data_o(rdata), .ack_i(ack), .mode_i(mode), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] ec, input logic ei);
    n_run++;
    if (rdata !== ec || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: cnt=%h irq=%b expected cnt=%h irq=%b", req, rdata, irq, ec, ei);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic step(input logic w, input logic [31:0] d, input logic t, input logic a);
    wr = w; wdata = d; tick = t; ack = a;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0; ack = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    mode = m; rst_n = 1'b0;
    @(negedge clk);
    check("R1 in reset", 32'hFFFFFFFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'hFFFFFFFF, 1'b0);
  endtask

  initial begin
    do_reset(1'b0);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].d, VEC[i].tick, VEC[i].ack);
      check($sformatf("edge vec %0d", i), VEC[i].exp_cnt, VEC[i].exp_irq);
    end

    // R1: reset mid-run drops a pending request
    step(1'b1, 32'h1, 1'b0, 1'b0);
    check("R5 pre-reset", 32'h1, 1'b1);
    do_reset(1'b1);

    // level mode
    step(1'b1, 32'h80000005, 1'b0, 1'b0);
    check("R9 msb write", 32'h80000005, 1'b1);
    step(1'b0, 32'h0, 1'b0, 1'b1);
    check("R11 ack ignored", 32'h80000005, 1'b1);
    step(1'b0, 32'h0, 1'b1, 1'b0);
    check("R3 level tick", 32'h80000004, 1'b1);
    step(1'b1, 32'h10, 1'b0, 1'b0);
    check("R10 clear", 32'h10, 1'b0);
    step(1'b1, 32'h1, 1'b0, 1'b0);
    check("R5 level small", 32'h1, 1'b1);
    step(1'b1, 32'h3, 1'b0, 1'b1);
    check("R10 clear at 3", 32'h3, 1'b0);
    step(1'b0, 32'h0, 1'b1, 1'b0);
    check("R4 level 3->2", 32'h2, 1'b0);
    step(1'b0, 32'h0, 1'b1, 1'b0);
    check("R4 level 2->1", 32'h1, 1'b1);
    step(1'b0, 32'h0, 1'b0, 1'b1);
    check("R11 ack no effect", 32'h1, 1'b1);
    step(1'b1, 32'h20, 1'b1, 1'b0);
    check("R2 write beats tick", 32'h20, 1'b0);
    step(1'b1, 32'h80000000, 1'b0, 1'b1);
    check("R9 with ack", 32'h80000000, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule